// File: doc/BRIEF.md
# Infrared Pulse-Distance Packet Transmitter

This block turns four active-high request lines into a repeating infrared packet on a single output that drives an IR LED. Each symbol is a fixed-length burst of a square-wave carrier. A silent gap follows the burst, and the length of that gap carries the symbol's meaning. A packet opens with a header symbol. Three data bits follow, least significant first, and then the complements of the same three bits in the same order. A final burst with no gap after it closes the packet.

All timing comes from a tick generator that divides the system clock twice. At the defaults it divides 8 MHz by 8 and then by 100, which gives 100 µs per tick. A carrier generator toggles every 105 system clocks, which gives about 38.1 kHz. A sequencer picks the highest-priority request and sends its 3-bit code. After each packet it waits a rest period of 200 ticks. It then sends the packet again if the same request is still high.

Top module: `irtx_packet_tx`

## Requirements
- R1: One tick lasts PRESCALE*TICK_WRAP clocks (800 at the defaults). Every burst and gap is a whole number of ticks, counted from the first burst of the packet.
- R2: While a burst is active, ir_out starts high and toggles every CARRIER_HALF clocks. At all other times ir_out is low. The carrier phase restarts at every burst.
- R3: Each burst lasts BURST_TICKS ticks (6).
- R4: The time between the starts of consecutive bursts is BURST_TICKS plus the gap. The gap is HEADER_GAP (30) after the header, ONE_GAP (10) after a 1 bit and ZERO_GAP (20) after a 0 bit.
- R5: The bursts come in this order: header, code bits 0, 1, 2, then the complements of bits 0, 1, 2, then one closing burst.
- R6: Request 0 sends code 3'b001, request 1 sends 3'b100, request 2 sends 3'b101 and request 3 sends 3'b111. Bit 0 is sent first.
- R7: When several requests are high, the lowest-numbered request wins.
- R8: After the closing burst the block waits REPEAT_GAP ticks (200). If the selected request is still high, the next header starts 6+200 ticks after the closing burst started. The selection is kept for the whole repeat, and other requests are ignored until the block returns to idle.
- R9: Dropping the request partway through a packet does not shorten that packet. The block goes idle after the rest period and sends nothing more.
- R10: A synchronous active-high reset returns the block to idle with ir_out low. While no request is present, no burst follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Active-high send requests; bit 0 has the highest priority |
| ir_out | output | 1 | Carrier-gated output for the IR LED |

## Verification
The carrier output register follows the sequencer's burst register by one clock. A burst therefore appears on ir_out two edges after the request is taken, and every later burst appears with the same one-clock lag. The checks time each burst start from the first high sample after a long silence and compare the intervals between starts. Because every start carries the same lag, the fixed latency cancels. The one exception is a new packet taken from idle, which adds exactly one idle clock to the interval, and the check expects that extra clock. Carrier shape, high-cycle counts per burst and the absence of further bursts are checked only after the rest period has fully elapsed.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  localparam int unsigned NUM_REQ = 4;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned SEG_W   = 3;

  localparam logic [SEG_W-1:0] SEG_HEADER = 3'd0;
  localparam logic [SEG_W-1:0] SEG_CLOSE  = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_GAP   = 2'd2,
    ST_REST  = 2'd3
  } seq_state_t;

  // Lowest set index wins.
  function automatic logic [1:0] pick_request(input logic [NUM_REQ-1:0] r);
    if (r[0])      return 2'd0;
    else if (r[1]) return 2'd1;
    else if (r[2]) return 2'd2;
    else           return 2'd3;
  endfunction

  function automatic logic [CODE_W-1:0] code_for(input logic [1:0] idx);
    case (idx)
      2'd0:    return 3'b001;
      2'd1:    return 3'b100;
      2'd2:    return 3'b101;
      default: return 3'b111;
    endcase
  endfunction

  // Bit carried by a data segment: 1..3 true bits, 4..6 complements.
  function automatic logic seg_bit(input logic [SEG_W-1:0] seg,
                                   input logic [CODE_W-1:0] code);
    case (seg)
      3'd1:    return code[0];
      3'd2:    return code[1];
      3'd3:    return code[2];
      3'd4:    return ~code[0];
      3'd5:    return ~code[1];
      3'd6:    return ~code[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irtx_tick_gen.sv
module irtx_tick_gen #(
  parameter int unsigned PRESCALE  = 8,
  parameter int unsigned TICK_WRAP = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick_o
);
  localparam int unsigned PRE_W = (PRESCALE  > 1) ? $clog2(PRESCALE)  : 1;
  localparam int unsigned DIV_W = (TICK_WRAP > 1) ? $clog2(TICK_WRAP) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic             pre_wrap;
  logic             div_wrap;

  assign pre_wrap = (pre_q == PRE_W'(PRESCALE - 1));
  assign div_wrap = (div_q == DIV_W'(TICK_WRAP - 1));
  assign tick_o   = run && pre_wrap && div_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      div_q <= div_wrap ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (PRESCALE * TICK_WRAP > 1) begin : g_spacing
      // R1: ticks are never back to back
      a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate

  // R1: a restarted divider needs a full period before its first tick
  a_r1_fresh_start: assert property (@(posedge clk) disable iff (rst)
    (!run && (PRESCALE * TICK_WRAP > 1)) |=> !tick_o);

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int unsigned CARRIER_HALF = 105
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic carrier_o
);
  localparam int unsigned HC_W = (CARRIER_HALF > 1) ? $clog2(CARRIER_HALF) : 1;

  logic [HC_W-1:0] cnt_q;
  logic            live_q;
  logic            phase_q;
  logic            half_done;

  assign half_done = (cnt_q == HC_W'(CARRIER_HALF - 1));
  assign carrier_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q   <= '0;
      live_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (!live_q) begin
      live_q  <= 1'b1;
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (half_done) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: output goes dark once the burst enable drops
  a_r2_dark_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !carrier_o);

  // R2: every burst starts on a high phase
  a_r2_starts_high: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> carrier_o);

  // R2: phase holds between half-period boundaries
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (en && live_q && !half_done) |=> (!en || $stable(carrier_o)));

endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
  import irtx_pkg::*;
#(
  parameter int unsigned BURST_TICKS = 6,
  parameter int unsigned HEADER_GAP  = 30,
  parameter int unsigned ONE_GAP     = 10,
  parameter int unsigned ZERO_GAP    = 20,
  parameter int unsigned REPEAT_GAP  = 200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req,
  input  logic               tick,
  output logic               run_o,
  output logic               burst_o
);
  localparam int unsigned MAX_A  = (BURST_TICKS > HEADER_GAP) ? BURST_TICKS : HEADER_GAP;
  localparam int unsigned MAX_B  = (ONE_GAP > ZERO_GAP) ? ONE_GAP : ZERO_GAP;
  localparam int unsigned MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_T  = (MAX_C > REPEAT_GAP) ? MAX_C : REPEAT_GAP;
  localparam int unsigned TCNT_W = $clog2(MAX_T + 1);

  seq_state_t        state_q;
  logic [SEG_W-1:0]  seg_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic [1:0]        sel_q;
  logic [CODE_W-1:0] code_q;
  logic              burst_q;

  // named internal events
  logic              start_req;
  logic              burst_last;
  logic              gap_last;
  logic              rest_last;
  logic              repeat_ok;
  logic [TCNT_W-1:0] cur_gap;

  always_comb begin
    if (seg_q == SEG_HEADER)        cur_gap = TCNT_W'(HEADER_GAP);
    else if (seg_bit(seg_q, code_q)) cur_gap = TCNT_W'(ONE_GAP);
    else                             cur_gap = TCNT_W'(ZERO_GAP);
  end

  assign start_req  = |req;
  assign burst_last = tick && (tcnt_q == TCNT_W'(BURST_TICKS - 1));
  assign gap_last   = tick && (tcnt_q == cur_gap - 1'b1);
  assign rest_last  = tick && (tcnt_q == TCNT_W'(REPEAT_GAP - 1));
  assign repeat_ok  = req[sel_q];
  assign run_o      = (state_q != ST_IDLE);
  assign burst_o    = burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seg_q   <= SEG_HEADER;
      tcnt_q  <= '0;
      sel_q   <= '0;
      code_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            sel_q   <= pick_request(req);
            code_q  <= code_for(pick_request(req));
            seg_q   <= SEG_HEADER;
            tcnt_q  <= '0;
            burst_q <= 1'b1;
            state_q <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (burst_last) begin
            tcnt_q  <= '0;
            burst_q <= 1'b0;
            state_q <= (seg_q == SEG_CLOSE) ? ST_REST : ST_GAP;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            tcnt_q  <= '0;
            seg_q   <= seg_q + 1'b1;
            burst_q <= 1'b1;
            state_q <= ST_BURST;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: begin
          if (rest_last) begin
            tcnt_q <= '0;
            if (repeat_ok) begin
              seg_q   <= SEG_HEADER;
              burst_q <= 1'b1;
              state_q <= ST_BURST;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R3: the burst enable is only ever high in the burst state
  a_r3_burst_in_state: assert property (@(posedge clk) disable iff (rst)
    burst_q |-> (state_q == ST_BURST));

  // R4: the gap counter stays below the length chosen for its segment
  a_r4_gap_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> (tcnt_q < cur_gap));

  // R5: the closing burst is followed by the rest period, not a gap
  a_r5_close_then_rest: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BURST && seg_q == SEG_CLOSE && burst_last) |=> (state_q == ST_REST));

  // R8: the selection does not change while a packet train is active
  a_r8_sel_held: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(sel_q));

  // R9: a packet is never abandoned from a gap
  a_r9_no_abort: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |=> (state_q != ST_IDLE));

  // R10: reset lands in idle with the burst off
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && !burst_q));

endmodule

// File: rtl/irtx_packet_tx.sv
module irtx_packet_tx
  import irtx_pkg::*;
#(
  parameter int unsigned PRESCALE     = 8,
  parameter int unsigned TICK_WRAP    = 100,
  parameter int unsigned CARRIER_HALF = 105,
  parameter int unsigned BURST_TICKS  = 6,
  parameter int unsigned HEADER_GAP   = 30,
  parameter int unsigned ONE_GAP      = 10,
  parameter int unsigned ZERO_GAP     = 20,
  parameter int unsigned REPEAT_GAP   = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] req,
  output logic       ir_out
);
  logic seq_run;
  logic seq_burst;
  logic tick;

  irtx_tick_gen #(
    .PRESCALE  (PRESCALE),
    .TICK_WRAP (TICK_WRAP)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (seq_run),
    .tick_o (tick)
  );

  irtx_sequencer #(
    .BURST_TICKS (BURST_TICKS),
    .HEADER_GAP  (HEADER_GAP),
    .ONE_GAP     (ONE_GAP),
    .ZERO_GAP    (ZERO_GAP),
    .REPEAT_GAP  (REPEAT_GAP)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .tick    (tick),
    .run_o   (seq_run),
    .burst_o (seq_burst)
  );

  irtx_carrier #(
    .CARRIER_HALF (CARRIER_HALF)
  ) u_carrier (
    .clk       (clk),
    .rst       (rst),
    .en        (seq_burst),
    .carrier_o (ir_out)
  );

  // R10: output stays dark while the sequencer is idle
  a_r10_idle_dark: assert property (@(posedge clk) disable iff (rst)
    (!seq_run && !$past(seq_run)) |-> !ir_out);

endmodule

// File: tb/irtx_packet_tx_test.sv
`timescale 1ns/1ps
module irtx_packet_tx_test;
  localparam int P     = 2;
  localparam int W     = 5;
  localparam int HALF  = 3;
  localparam int T     = P * W;
  localparam int BURST = 6;
  localparam int HDR   = 30;
  localparam int ONE   = 10;
  localparam int ZERO  = 20;
  localparam int REST  = 200;
  localparam int LIMIT = 190000;

  // {request pattern, expected code}
  localparam logic [6:0] VEC [6] = '{
    {4'b0001, 3'b001},
    {4'b0010, 3'b100},
    {4'b0100, 3'b101},
    {4'b1000, 3'b111},
    {4'b1111, 3'b001},
    {4'b1100, 3'b101}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = 4'b0;
  logic       ir_out;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int nstarts = 0;
  int quiet = 1000;
  int bidx = 0;
  int starts [64];
  int highs [64];
  logic [11:0] pat0;

  always #2 clk = ~clk;

  irtx_packet_tx #(
    .PRESCALE(P), .TICK_WRAP(W), .CARRIER_HALF(HALF),
    .BURST_TICKS(BURST), .HEADER_GAP(HDR), .ONE_GAP(ONE),
    .ZERO_GAP(ZERO), .REPEAT_GAP(REST)
  ) uut (
    .clk(clk), .rst(rst), .req(req), .ir_out(ir_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // burst monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (ir_out) begin
      if (quiet > 2 * HALF && nstarts < 64) begin
        starts[nstarts] = cyc;
        highs[nstarts] = 0;
        nstarts++;
        bidx = 0;
      end
      if (nstarts > 0) highs[nstarts-1]++;
      quiet = 0;
    end else begin
      quiet++;
    end
    if (nstarts == 1 && bidx < 12) begin
      pat0[11-bidx] = ir_out;
      bidx++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    nstarts = 0;
    quiet = 1000;
    bidx = 0;
    pat0 = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = 4'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_mon();
  endtask

  task automatic wait_starts(input int n);
    for (int i = 0; i < 20000 && nstarts < n; i++) @(negedge clk);
  endtask

  function automatic int seg_len(input int k, input logic [2:0] code);
    logic b;
    if (k == 0) return (BURST + HDR) * T;
    b = (k <= 3) ? code[k-1] : ~code[k-4];
    return (BURST + (b ? ONE : ZERO)) * T;
  endfunction

  // R1 R4 R5 R6: seven start-to-start intervals of one packet
  task automatic chk_packet(input int base, input logic [2:0] code, input string tag);
    for (int k = 0; k < 7; k++)
      chk($sformatf("R1/R4/R5/R6 %s seg %0d", tag, k),
          starts[base+k+1] - starts[base+k], seg_len(k, code));
  endtask

  function automatic logic [11:0] exp_pat();
    logic [11:0] p;
    for (int i = 0; i < 12; i++) p[11-i] = ((i / HALF) % 2) == 0;
    return p;
  endfunction

  function automatic int exp_highs();
    int len;
    len = BURST * T;
    return (len / (2 * HALF)) * HALF + (((len % (2 * HALF)) > HALF) ? HALF : (len % (2 * HALF)));
  endfunction

  initial begin
    // R10: reset state and quiet idle
    do_reset();
    chk("R10 ir_out after reset", int'(ir_out), 0);
    repeat (300) @(negedge clk);
    chk("R10 no burst while idle", nstarts, 0);

    // table walk: R6 codes, R7 priority, R8 repeat, R9 release
    for (int v = 0; v < 6; v++) begin
      do_reset();
      @(negedge clk);
      req = VEC[v][6:3];
      wait_starts(9);
      chk_packet(0, VEC[v][2:0], $sformatf("vec%0d", v));
      chk($sformatf("R8 vec%0d repeat interval", v), starts[8] - starts[7], (BURST + REST) * T);
      chk($sformatf("R3 vec%0d burst high cycles", v), highs[0], exp_highs());
      chk($sformatf("R2 vec%0d carrier shape", v), int'(pat0), int'(exp_pat()));
      @(negedge clk);
      req = 4'b0;
      wait_starts(16);
      repeat ((REST + 20) * T) @(negedge clk);
      chk_packet(8, VEC[v][2:0], $sformatf("R9 vec%0d second", v));
      chk($sformatf("R9 vec%0d bursts after release", v), nstarts, 16);
      chk($sformatf("R2 vec%0d dark after train", v), int'(ir_out), 0);
    end

    // R8: a higher request during a train is ignored until idle
    do_reset();
    @(negedge clk);
    req = 4'b0100;
    wait_starts(2);
    req = 4'b0101;
    wait_starts(9);
    req = 4'b0001;
    wait_starts(24);
    chk_packet(8, 3'b101, "R8 held selection");
    chk("R8 idle hop before new selection", starts[16] - starts[15], (BURST + REST) * T + 1);
    chk_packet(16, 3'b001, "R7 new selection after idle");
    @(negedge clk);
    req = 4'b0;
    repeat ((REST + 200) * T) @(negedge clk);

    // R10: reset in the middle of a packet
    do_reset();
    @(negedge clk);
    req = 4'b1000;
    wait_starts(3);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    req = 4'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 dark after mid-packet reset", int'(ir_out), 0);
    rst = 1'b0;
    clear_mon();
    repeat (2000) @(negedge clk);
    chk("R10 nothing sent after reset", nstarts, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule